// File: doc/BRIEF.md
# Parallel Host Bridge for a Sequencer's Character Port

This block takes the place of a serial character port between a data buffer's sequencer and a host. On the host side there are two parallel byte paths, each with 8 data bits and one handshake bit per direction. On the sequencer side the block offers the same signals the serial port used to offer. For received characters, these are a held receive bus, a data-ready flag and an active-low clear. For outgoing characters, these are a transmit bus, an active-low load strobe and a transmit-empty flag. The sequencer paces itself on that flag.

Host bytes arrive with a four-phase handshake. The host's strobe is synchronised, and its rising edge latches the byte, raises data-ready and raises the bridge's acknowledge. The acknowledge falls again once the host strobe has fallen. The received byte stays on the bus until a newer one replaces it, because the sequencer keeps acting on the last command character. For outgoing bytes, a load strobe from the sequencer latches the byte, drops transmit-empty and raises the outgoing strobe. The flag comes back only after the host has acknowledged and then released its acknowledge.

A select input hands the sequencer-facing signals back to the original serial port. The flags and receive bus then come from that port, and the sequencer's load and clear strobes go to it. While the select is high, the bridge ignores both strobes.

Top module: `par_uart_bridge`

## Requirements
- R1: After reset, transmit-empty is 1, data-ready is 0, the receive bus is 0x00, the host acknowledge and outgoing strobe are 0, and the outgoing host bus is 0x00.
- R2: The host strobe passes through two synchronising flops. On the third rising clock edge after it goes high, the host byte is latched onto the receive bus, and data-ready and the host acknowledge go to 1.
- R3: If the clear input is sampled low, data-ready falls at that edge and the receive bus keeps its value. If a new host byte is captured at the same edge, the capture wins and data-ready stays 1.
- R4: A host strobe held high captures only one byte, however long it stays high. The host acknowledge falls on the third rising edge after the host strobe goes low.
- R5: An edge where the load strobe is sampled low, after being sampled high on the edge before, while transmit-empty is 1, latches the transmit bus onto the outgoing host bus. At that same edge it raises the outgoing strobe and drops transmit-empty. A load while transmit-empty is 0 has no effect.
- R6: The outgoing strobe falls on the third edge after the host acknowledge goes high. Transmit-empty returns to 1 on the third edge after that acknowledge goes low again.
- R7: While the select is 1, the receive bus, data-ready and transmit-empty outputs mirror the serial port's signals. The serial port's load and clear inputs follow the sequencer's strobes. The bridge's own state ignores both strobes. While the select is 0, the serial load and clear are held at 1. The serial transmit bus always carries the sequencer's transmit bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| use_serial_i | input | 1 | 1 hands the sequencer side to the serial port |
| rx_data_o | output | W | Received byte bus toward the sequencer |
| rx_ready_o | output | 1 | Data-ready flag |
| rx_clr_n_i | input | 1 | Active-low data-ready clear from the sequencer |
| tx_data_i | input | W | Outgoing byte from the sequencer |
| tx_load_n_i | input | 1 | Active-low load strobe from the sequencer |
| tx_empty_o | output | 1 | Transmit-empty flag toward the sequencer |
| h_in_data_i | input | W | Byte from the host |
| h_in_stb_i | input | 1 | Host strobe for an incoming byte (asynchronous) |
| h_in_ack_o | output | 1 | Bridge acknowledge for an incoming byte |
| h_out_data_o | output | W | Byte toward the host |
| h_out_stb_o | output | 1 | Bridge strobe for an outgoing byte |
| h_out_ack_i | input | 1 | Host acknowledge for an outgoing byte (asynchronous) |
| ser_rx_data_i | input | W | Serial port receive bus |
| ser_rx_ready_i | input | 1 | Serial port data-ready |
| ser_tx_empty_i | input | 1 | Serial port transmit-empty |
| ser_rx_clr_n_o | output | 1 | Clear strobe routed to the serial port |
| ser_tx_data_o | output | W | Transmit bus routed to the serial port |
| ser_tx_load_n_o | output | 1 | Load strobe routed to the serial port |

## Verification
Two things can fall on the same edge: the capture of a new host byte, which sets data-ready, and the sequencer's clear, which drops it. The bench raises the host strobe and then holds the clear low across exactly the third following edge, which is the one where the capture lands. It expects data-ready to stay high with the new byte on the bus. A behavioural reference model runs in step with the design and judges every output on every clock. This covers a second overlap: a load strobe that arrives while a transmission is still waiting for the host.

// File: rtl/par_uart_bridge.sv
`timescale 1ns/1ps
module par_uart_bridge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         use_serial_i,
  output logic [W-1:0] rx_data_o,
  output logic         rx_ready_o,
  input  logic         rx_clr_n_i,
  input  logic [W-1:0] tx_data_i,
  input  logic         tx_load_n_i,
  output logic         tx_empty_o,
  input  logic [W-1:0] h_in_data_i,
  input  logic         h_in_stb_i,
  output logic         h_in_ack_o,
  output logic [W-1:0] h_out_data_o,
  output logic         h_out_stb_o,
  input  logic         h_out_ack_i,
  input  logic [W-1:0] ser_rx_data_i,
  input  logic         ser_rx_ready_i,
  input  logic         ser_tx_empty_i,
  output logic         ser_rx_clr_n_o,
  output logic [W-1:0] ser_tx_data_o,
  output logic         ser_tx_load_n_o
);

  logic [1:0]   stb_sync, ack_sync;
  logic         stb_prev, load_prev;
  logic [W-1:0] rx_q, tx_q;
  logic         dr_q, hack_q, hstb_q, tbre_q, wait_rel_q;

  wire stb_s    = stb_sync[1];
  wire ack_s    = ack_sync[1];
  wire stb_rise = stb_s & ~stb_prev;
  wire stb_fall = ~stb_s & stb_prev;
  wire clr_req  = ~use_serial_i & ~rx_clr_n_i;
  wire load_req = ~use_serial_i & load_prev & ~tx_load_n_i & tbre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_sync  <= '0;
      ack_sync  <= '0;
      stb_prev  <= 1'b0;
      load_prev <= 1'b1;
    end else begin
      stb_sync  <= {stb_sync[0], h_in_stb_i};
      ack_sync  <= {ack_sync[0], h_out_ack_i};
      stb_prev  <= stb_s;
      load_prev <= tx_load_n_i;
    end
  end

  // receive path: capture wins over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q   <= '0;
      dr_q   <= 1'b0;
      hack_q <= 1'b0;
    end else begin
      if (stb_rise) begin
        rx_q   <= h_in_data_i;
        dr_q   <= 1'b1;
        hack_q <= 1'b1;
      end else begin
        if (stb_fall) hack_q <= 1'b0;
        if (clr_req)  dr_q   <= 1'b0;
      end
    end
  end

  // transmit path
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q       <= '0;
      hstb_q     <= 1'b0;
      tbre_q     <= 1'b1;
      wait_rel_q <= 1'b0;
    end else if (load_req) begin
      tx_q       <= tx_data_i;
      hstb_q     <= 1'b1;
      tbre_q     <= 1'b0;
      wait_rel_q <= 1'b0;
    end else if (hstb_q && ack_s) begin
      hstb_q     <= 1'b0;
      wait_rel_q <= 1'b1;
    end else if (wait_rel_q && !ack_s) begin
      wait_rel_q <= 1'b0;
      tbre_q     <= 1'b1;
    end
  end

  assign rx_data_o       = use_serial_i ? ser_rx_data_i  : rx_q;
  assign rx_ready_o      = use_serial_i ? ser_rx_ready_i : dr_q;
  assign tx_empty_o      = use_serial_i ? ser_tx_empty_i : tbre_q;
  assign ser_rx_clr_n_o  = use_serial_i ? rx_clr_n_i  : 1'b1;
  assign ser_tx_load_n_o = use_serial_i ? tx_load_n_i : 1'b1;
  assign ser_tx_data_o   = tx_data_i;
  assign h_in_ack_o      = hack_q;
  assign h_out_data_o    = tx_q;
  assign h_out_stb_o     = hstb_q;

  assert_dr_with_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dr_q) |-> hack_q);
  assert_bus_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dr_q) |-> $stable(rx_q));
  assert_ack_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hack_q) |-> !stb_s);
  assert_busy_no_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tbre_q |=> $stable(tx_q));
  assert_empty_after_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tbre_q) |-> !ack_s && !hstb_q);
  assert_serial_ignores_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_q) |-> !$past(use_serial_i));
endmodule

// File: tb/par_uart_bridge_bench.sv
`timescale 1ns/1ps
module par_uart_bridge_bench;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic use_serial = 0, rx_clr_n = 1, tx_load_n = 1, h_in_stb = 0, h_out_ack = 0;
  logic ser_rx_ready = 0, ser_tx_empty = 0;
  logic [W-1:0] tx_data = 0, h_in_data = 0, ser_rx_data = 0;
  logic [W-1:0] rx_data, h_out_data, ser_tx_data;
  logic rx_ready, tx_empty, h_in_ack, h_out_stb, ser_rx_clr_n, ser_tx_load_n;

  par_uart_bridge #(.W(W)) u_par_uart_bridge (
    .clk(clk), .rst_n(rst_n), .use_serial_i(use_serial),
    .rx_data_o(rx_data), .rx_ready_o(rx_ready), .rx_clr_n_i(rx_clr_n),
    .tx_data_i(tx_data), .tx_load_n_i(tx_load_n), .tx_empty_o(tx_empty),
    .h_in_data_i(h_in_data), .h_in_stb_i(h_in_stb), .h_in_ack_o(h_in_ack),
    .h_out_data_o(h_out_data), .h_out_stb_o(h_out_stb), .h_out_ack_i(h_out_ack),
    .ser_rx_data_i(ser_rx_data), .ser_rx_ready_i(ser_rx_ready), .ser_tx_empty_i(ser_tx_empty),
    .ser_rx_clr_n_o(ser_rx_clr_n), .ser_tx_data_o(ser_tx_data), .ser_tx_load_n_o(ser_tx_load_n));

  int tests = 0, fails = 0;
  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model: host inputs seen through queues of past samples
  int stb_hist[$], ack_hist[$];
  int m_rx, m_dr, m_hack, m_out, m_stb, m_phase, m_lp;
  always @(posedge clk) begin
    if (!rst_n) begin
      stb_hist = '{0, 0, 0};
      ack_hist = '{0, 0};
      m_rx = 0; m_dr = 0; m_hack = 0; m_out = 0; m_stb = 0; m_phase = 0; m_lp = 1;
    end else begin
      int seen_now, seen_old, ack_seen;
      seen_now = stb_hist[1];
      seen_old = stb_hist[0];
      ack_seen = ack_hist[0];
      if (seen_now == 1 && seen_old == 0) begin
        m_rx = h_in_data; m_dr = 1; m_hack = 1;
      end else begin
        if (seen_now == 0 && seen_old == 1) m_hack = 0;
        if (!use_serial && !rx_clr_n) m_dr = 0;
      end
      if (!use_serial && m_lp == 1 && !tx_load_n && m_phase == 0) begin
        m_out = tx_data; m_stb = 1; m_phase = 1;
      end else if (m_phase == 1 && ack_seen == 1) begin
        m_stb = 0; m_phase = 2;
      end else if (m_phase == 2 && ack_seen == 0) begin
        m_phase = 0;
      end
      m_lp = tx_load_n;
      void'(stb_hist.pop_front()); stb_hist.push_back(int'(h_in_stb));
      void'(ack_hist.pop_front()); ack_hist.push_back(int'(h_out_ack));
      #1;
      chk("R2 rx_data", rx_data, use_serial ? ser_rx_data : m_rx);
      chk("R3 data_ready", rx_ready, use_serial ? ser_rx_ready : m_dr);
      chk("R4 host_ack", h_in_ack, m_hack);
      chk("R5 host_out_data", h_out_data, m_out);
      chk("R6 host_out_stb", h_out_stb, m_stb);
      chk("R6 tx_empty", tx_empty, use_serial ? ser_tx_empty : (m_phase == 0));
      chk("R7 ser_load", ser_tx_load_n, use_serial ? tx_load_n : 1);
      chk("R7 ser_clr", ser_rx_clr_n, use_serial ? rx_clr_n : 1);
      chk("R7 ser_data", ser_tx_data, tx_data);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 data_ready", rx_ready, 0);
    chk("R1 rx_data", rx_data, 0);
    chk("R1 host_ack", h_in_ack, 0);
    chk("R1 host_stb", h_out_stb, 0);
    rst_n = 1;
    idle(2);

    // R2: host byte captured on the third edge
    h_in_data = 8'hA5; h_in_stb = 1;
    idle(2);
    chk("R2 not yet", rx_ready, 0);
    idle(1);
    chk("R2 captured", rx_data, 8'hA5);
    chk("R2 ready", rx_ready, 1);
    // R4: held strobe, new data not captured
    h_in_data = 8'h11;
    idle(6);
    chk("R4 single capture", rx_data, 8'hA5);
    h_in_stb = 0;
    idle(3);
    chk("R4 ack released", h_in_ack, 0);

    // R3: clear keeps the bus
    rx_clr_n = 0; idle(1); rx_clr_n = 1;
    chk("R3 cleared", rx_ready, 0);
    chk("R3 bus held", rx_data, 8'hA5);
    idle(4);
    chk("R3 bus still held", rx_data, 8'hA5);

    // R3: capture and clear on the same edge
    h_in_data = 8'h3C; h_in_stb = 1;
    idle(2);
    rx_clr_n = 0; idle(1); rx_clr_n = 1;
    chk("R3 capture wins", rx_ready, 1);
    chk("R3 new byte", rx_data, 8'h3C);
    h_in_stb = 0; idle(5);

    // R5/R6: outgoing byte
    tx_data = 8'h5A; tx_load_n = 0; idle(1); tx_load_n = 1;
    chk("R5 empty low", tx_empty, 0);
    chk("R5 strobe", h_out_stb, 1);
    chk("R5 out data", h_out_data, 8'h5A);
    idle(1);
    tx_data = 8'hFF; tx_load_n = 0; idle(1); tx_load_n = 1;
    chk("R5 busy load ignored", h_out_data, 8'h5A);
    h_out_ack = 1; idle(2);
    chk("R6 strobe still high", h_out_stb, 1);
    idle(1);
    chk("R6 strobe dropped", h_out_stb, 0);
    chk("R6 empty still low", tx_empty, 0);
    idle(3);
    h_out_ack = 0; idle(2);
    chk("R6 empty waits", tx_empty, 0);
    idle(1);
    chk("R6 empty back", tx_empty, 1);

    // back-to-back bytes with a responsive host
    for (int b = 0; b < 4; b++) begin
      tx_data = 8'(8'h20 + b); tx_load_n = 0; idle(1); tx_load_n = 1;
      chk("R5 burst data", h_out_data, 8'h20 + b);
      h_out_ack = 1; idle(3); h_out_ack = 0; idle(3);
      chk("R6 burst empty", tx_empty, 1);
    end

    // R7: serial port takes over
    use_serial = 1; ser_rx_data = 8'h77; ser_rx_ready = 1; ser_tx_empty = 0;
    idle(1);
    chk("R7 rx mux", rx_data, 8'h77);
    chk("R7 empty mux", tx_empty, 0);
    tx_data = 8'h99; tx_load_n = 0; rx_clr_n = 0; idle(1);
    chk("R7 load routed", ser_tx_load_n, 0);
    chk("R7 clr routed", ser_rx_clr_n, 0);
    tx_load_n = 1; rx_clr_n = 1; idle(1);
    chk("R7 bridge ignores load", h_out_stb, 0);
    use_serial = 0; idle(1);
    chk("R7 bridge ready kept", rx_ready, 1);
    chk("R7 bridge bus kept", rx_data, 8'h3C);
    chk("R7 out data kept", h_out_data, 8'h23);
    chk("R7 empty restored", tx_empty, 1);
    idle(4);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule